// File: doc/BRIEF.md
# Codec Powerdown Controller

This block is the power management slice of an audio codec's digital control plane. It holds a seven-bit powerdown request field, reachable through a register at index 0x26. Each request bit switches off one subsection, and any mix of bits may be set together. The block drives an enable for each subsection: the ADCs with the input mux, the DACs, the mixer, the reference, the serial link and the internal clock. A per-subsection counter models power-up time, and a read-only ready flag reports when each analog subsection can be used.

The block also stands in the path of the serial link. When the link is shut down, the bit clock output is gated off and the outgoing link data is held low. The incoming frame sync and serial data are masked, so no frame logic sees them. While the link is down, register writes are dropped, so only a reset can revive it. The active-low `rst_n` is the cold reset: it restores every default. The one-cycle `warm_rst` clears only the link-shutdown request. A global shutdown can be left only through a cold reset.

Register access is plain control-plane signalling with no handshake. A write completes in the cycle `reg_wr` is high. A read returns the register combinationally whenever `reg_idx` selects it; any other index reads as zero. Audio signals are never muted by this block; muting is left to software.

Top module: `codec_pwr_ctl`

## Requirements
- R1: After cold reset, the request field (read bits [14:8]) is zero and all enables are high. The four ready flags (read bits [3:0]: bit0 ADC, bit1 DAC, bit2 mixer, bit3 reference) all read 1 once the longest power-up delay has passed.
- R2: A write at index 0x26 loads request bits PR0..PR6 from write data bits [8..14]. Writes at any other index change nothing, and write data in the ready positions [3:0] never alters the ready flags.
- R3: Once PR0 is loaded, the ADC enable is low and the ADC ready flag reads 0 in the next cycle; no delay is modelled here.
- R4: PR1 drops the DAC enable and ready flag. PR2 drops the mixer. PR3 drops both the mixer and the reference.
- R5: When the last of PR2/PR3 is cleared, the mixer ready flag stays 0 for MIX_DLY-1 cycles after the write and reads 1 in cycle MIX_DLY. The other flags follow their own delays in the same way.
- R6: With PR4 set, the link enable is low, `bclk_out` and `sdin_out` are held low, and `sync_out` and `sdout_out` are held low whatever their sources do.
- R7: While the link is down (PR4 or PR5 set), register writes are ignored.
- R8: A warm reset clears PR4 and leaves every other request bit unchanged, which brings the link back.
- R9: PR5 drops every enable and every ready flag. A warm reset does not change the register while PR5 is set; only a cold reset recovers.
- R10: PR6 drops only the internal-clock enable.
- R11: No signal is muted: with the link up, `sdin_out` follows `sdin_src` whatever the other request bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control-plane clock |
| rst_n | input | 1 | Cold reset, active low, asynchronous |
| warm_rst | input | 1 | Warm reset pulse, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | IW | Register index |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for the selected index |
| en_adc | output | 1 | ADC and input mux enable |
| en_dac | output | 1 | DAC enable |
| en_mix | output | 1 | Mixer enable |
| en_ref | output | 1 | Reference voltage enable |
| en_link | output | 1 | Serial link enable |
| en_iclk | output | 1 | Internal clock enable |
| bclk_src | input | 1 | Bit clock from the clock generator |
| bclk_out | output | 1 | Gated bit clock to the link |
| sdin_src | input | 1 | Outgoing link data from the frame logic |
| sdin_out | output | 1 | Outgoing link data, forced low when down |
| sync_in | input | 1 | Frame sync from the link |
| sync_out | output | 1 | Frame sync to the frame logic, masked when down |
| sdout_in | input | 1 | Incoming link data |
| sdout_out | output | 1 | Incoming link data to the frame logic, masked when down |

## Verification
The hardest states to reach are the locked ones. Once PR4 or PR5 is loaded, the port that programs the block stops listening, so every later step must come from the reset inputs. The stimulus first drives the lock through a normal write. It then tries a clearing write and checks that the register did not move. It ends with a warm reset, which must clear only the link bit, or, under PR5, must do nothing until a cold reset. Ready timing is checked cycle by cycle, one sample before the expected rise and one at it.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;
  localparam int NREQ    = 7;
  localparam int NRDY    = 4;
  localparam int REQ_LSB = 8;

  localparam int B_ADC  = 0;
  localparam int B_DAC  = 1;
  localparam int B_MIX  = 2;
  localparam int B_REF  = 3;
  localparam int B_LINK = 4;
  localparam int B_ALL  = 5;
  localparam int B_ICLK = 6;

  typedef logic [NREQ-1:0] req_t;
  typedef logic [NRDY-1:0] rdy_t;
endpackage

// File: rtl/cpd_req_reg.sv
module cpd_req_reg
  import codec_pwr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic warm_rst,
  input  logic wr_en,
  input  req_t wdata,
  output req_t req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= '0;
    end else if (warm_rst && !req[B_ALL]) begin
      req[B_LINK] <= 1'b0;
    end else if (wr_en) begin
      req <= wdata;
    end
  end

  AST_WARM_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_rst && !req[B_ALL]) |=> (!req[B_LINK] && req[3:0] == $past(req[3:0])
                                   && req[6:5] == $past(req[6:5]))); // R8

  AST_WARM_IDLE_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_rst && req[B_ALL] && !wr_en) |=> $stable(req)); // R9
endmodule

// File: rtl/cpd_ready_timer.sv
module cpd_ready_timer #(
  parameter int DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic ready
);
  localparam int CW = (DLY < 1) ? 1 : $clog2(DLY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DLY);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en) begin
      cnt <= '0;
    end else if (cnt != LIMIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ready = en && (cnt == LIMIT);

  AST_RDY_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> !ready); // R5

  AST_RDY_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(en)); // R5
endmodule

// File: rtl/cpd_link_gate.sv
module cpd_link_gate (
  input  logic en,
  input  logic bclk_src,
  input  logic sdin_src,
  input  logic sync_in,
  input  logic sdout_in,
  output logic bclk_out,
  output logic sdin_out,
  output logic sync_out,
  output logic sdout_out
);
  assign bclk_out  = bclk_src & en;
  assign sdin_out  = sdin_src & en;
  assign sync_out  = sync_in  & en;
  assign sdout_out = sdout_in & en;
endmodule

// File: rtl/codec_pwr_ctl.sv
module codec_pwr_ctl
  import codec_pwr_pkg::*;
#(
  parameter int IW      = 8,
  parameter int DW      = 16,
  parameter int REG_IDX = 'h26,
  parameter int ADC_DLY = 4,
  parameter int DAC_DLY = 5,
  parameter int MIX_DLY = 6,
  parameter int REF_DLY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          warm_rst,
  input  logic          reg_wr,
  input  logic [IW-1:0] reg_idx,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          en_adc,
  output logic          en_dac,
  output logic          en_mix,
  output logic          en_ref,
  output logic          en_link,
  output logic          en_iclk,
  input  logic          bclk_src,
  output logic          bclk_out,
  input  logic          sdin_src,
  output logic          sdin_out,
  input  logic          sync_in,
  output logic          sync_out,
  input  logic          sdout_in,
  output logic          sdout_out
);
  localparam logic [IW-1:0] IDX = IW'(REG_IDX);
  localparam int DLY_TAB [NRDY] = '{ADC_DLY, DAC_DLY, MIX_DLY, REF_DLY};

  req_t req;
  rdy_t rdy_en;
  rdy_t ready;
  logic hit;
  logic wr_ok;
  logic alive;

  assign hit   = (reg_idx == IDX);
  assign wr_ok = reg_wr && hit && en_link;

  cpd_req_reg u_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .warm_rst (warm_rst),
    .wr_en    (wr_ok),
    .wdata    (reg_wdata[REQ_LSB +: NREQ]),
    .req      (req)
  );

  assign alive   = !req[B_ALL];
  assign en_adc  = alive && !req[B_ADC];
  assign en_dac  = alive && !req[B_DAC];
  assign en_mix  = alive && !req[B_MIX] && !req[B_REF];
  assign en_ref  = alive && !req[B_REF];
  assign en_link = alive && !req[B_LINK];
  assign en_iclk = alive && !req[B_ICLK];

  assign rdy_en = {en_ref, en_mix, en_dac, en_adc};

  for (genvar g = 0; g < NRDY; g++) begin : g_tmr
    cpd_ready_timer #(.DLY(DLY_TAB[g])) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (rdy_en[g]),
      .ready (ready[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      reg_rdata[REQ_LSB +: NREQ] = req;
      reg_rdata[NRDY-1:0]        = ready;
    end
  end

  cpd_link_gate u_link (
    .en        (en_link),
    .bclk_src  (bclk_src),
    .sdin_src  (sdin_src),
    .sync_in   (sync_in),
    .sdout_in  (sdout_in),
    .bclk_out  (bclk_out),
    .sdin_out  (sdin_out),
    .sync_out  (sync_out),
    .sdout_out (sdout_out)
  );

  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_link && !warm_rst) |=> $stable(req)); // R7

  AST_GLOBAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    req[B_ALL] |=> req[B_ALL]); // R9

  AST_GLOBAL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req[B_ALL]) |-> (ready == '0)); // R9
endmodule

// File: tb/sim_codec_pwr_ctl.sv
module sim_codec_pwr_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        warm_rst = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_idx = 8'h26;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic en_adc, en_dac, en_mix, en_ref, en_link, en_iclk;
  logic bclk_src = 1'b1, sdin_src = 1'b1, sync_in = 1'b1, sdout_in = 1'b1;
  logic bclk_out, sdin_out, sync_out, sdout_out;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  codec_pwr_ctl u0 (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .reg_wr(reg_wr),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .en_adc(en_adc), .en_dac(en_dac), .en_mix(en_mix), .en_ref(en_ref),
    .en_link(en_link), .en_iclk(en_iclk),
    .bclk_src(bclk_src), .bclk_out(bclk_out), .sdin_src(sdin_src),
    .sdin_out(sdin_out), .sync_in(sync_in), .sync_out(sync_out),
    .sdout_in(sdout_in), .sdout_out(sdout_out)
  );

  typedef struct packed {
    logic [6:0] req;
    logic [5:0] en;   // {iclk, link, ref, mix, dac, adc}
  } vec_t;

  localparam vec_t VT [7] = '{
    '{7'h01, 6'b111110},   // R3
    '{7'h02, 6'b111101},   // R4
    '{7'h04, 6'b111011},   // R4
    '{7'h08, 6'b110011},   // R4
    '{7'h40, 6'b011111},   // R10
    '{7'h0F, 6'b110000},   // R4
    '{7'h00, 6'b111111}    // R5
  };

  function automatic logic [5:0] ens();
    return {en_iclk, en_link, en_ref, en_mix, en_dac, en_adc};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] idx, input logic [15:0] d);
    @(negedge clk);
    reg_idx = idx; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_idx = 8'h26;
  endtask

  task automatic wreq(input logic [6:0] r);
    wr(8'h26, {1'b0, r, 8'h00});
  endtask

  task automatic warm();
    @(negedge clk); warm_rst = 1'b1;
    @(negedge clk); warm_rst = 1'b0;
  endtask

  task automatic cold();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    chk("R1 request after cold reset", {9'd0, reg_rdata[14:8]}, 16'h0);
    chk("R1 ready low right after reset", {12'd0, reg_rdata[3:0]}, 16'h0);
    chk("R1 enables after reset", {10'd0, ens()}, 16'h003F);
    idle(8);
    chk("R1 ready after delays", {12'd0, reg_rdata[3:0]}, 16'h000F);

    for (int i = 0; i < 7; i++) begin
      wreq(VT[i].req);
      chk("R2 table request readback", {9'd0, reg_rdata[14:8]}, {9'd0, VT[i].req});
      chk("R4 table enables", {10'd0, ens()}, {10'd0, VT[i].en});
      idle(8);
      chk("R5 table settled ready", {12'd0, reg_rdata[3:0]}, {12'd0, VT[i].en[3:0]});
    end

    wr(8'h24, 16'h7F00);
    chk("R2 other index ignored", {9'd0, reg_rdata[14:8]}, 16'h0);
    reg_idx = 8'h24;
    #1 chk("R2 other index reads zero", reg_rdata, 16'h0);
    reg_idx = 8'h26;
    wr(8'h26, 16'h0000);
    wr(8'h26, 16'h000F);
    chk("R2 ready bits not writable", {12'd0, reg_rdata[3:0]}, 16'h000F);

    wreq(7'h01);
    chk("R3 adc ready drops at once", {15'd0, reg_rdata[0]}, 16'h0);
    chk("R3 adc enable low", {15'd0, en_adc}, 16'h0);
    sdin_src = 1'b1;
    #1 chk("R11 sdin passes with PR0 set", {15'd0, sdin_out}, 16'h1);
    sdin_src = 1'b0;
    #1 chk("R11 sdin follows low", {15'd0, sdin_out}, 16'h0);
    sdin_src = 1'b1;
    wreq(7'h00);

    idle(8);
    wreq(7'h04);
    wreq(7'h00);
    idle(5);
    chk("R5 mixer ready one cycle early", {15'd0, reg_rdata[2]}, 16'h0);
    idle(1);
    chk("R5 mixer ready on time", {15'd0, reg_rdata[2]}, 16'h1);

    wreq(7'h11);
    chk("R6 link enable low", {15'd0, en_link}, 16'h0);
    chk("R6 outputs forced low", {12'd0, bclk_out, sdin_out, sync_out, sdout_out}, 16'h0);
    wreq(7'h00);
    chk("R7 write ignored while link down", {9'd0, reg_rdata[14:8]}, 16'h0011);
    warm();
    chk("R8 warm clears only PR4", {9'd0, reg_rdata[14:8]}, 16'h0001);
    chk("R8 link restored", {14'd0, en_link, bclk_out}, 16'h0003);
    wreq(7'h00);

    wreq(7'h24);
    chk("R9 all enables low", {10'd0, ens()}, 16'h0);
    idle(8);
    chk("R9 all ready low", {12'd0, reg_rdata[3:0]}, 16'h0);
    warm();
    chk("R9 warm has no effect", {9'd0, reg_rdata[14:8]}, 16'h0024);
    wreq(7'h00);
    chk("R9 write cannot leave global", {9'd0, reg_rdata[14:8]}, 16'h0024);
    cold();
    chk("R9 cold reset clears global", {9'd0, reg_rdata[14:8]}, 16'h0);
    idle(8);
    chk("R1 ready after cold recovery", {12'd0, reg_rdata[3:0]}, 16'h000F);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule